// File: doc/BRIEF.md
# Configurable TX Packet Assembler

This block turns one packet at a time into a serial chip stream for a transmit modulator. A packet has five parts in this order: an alternating preamble, a fixed sync word, a programmable number of header bytes, a payload pulled from an upstream byte source, and a 16-bit checksum. Every part except the preamble can optionally be Manchester coded. The payload can optionally be whitened with a pseudorandom sequence. Bytes can be sent least significant bit first.

Software-visible configuration arrives as plain input vectors and must be held steady while a packet is in flight. A one-cycle `start` pulse launches a packet. The payload arrives over a valid/ready handshake. Chips appear on `bit_out` on every cycle where `bit_en` is high. Internal byte-load cycles and payload stalls drop `bit_en`, so the downstream modulator has to pace itself on that strobe. `busy` shows that a packet is in progress, and `sent` reports that the last one has finished.

Top module: `tx_pkt_assembler`

## Requirements
- R1: After reset, `busy`, `sent`, `bit_en` and `pay_ready` are all low.
- R2: The preamble is 4×`cfg_pre_nibbles` chips of alternating value, and the first chip is 1. It is never Manchester coded, whitened or reordered. A count of zero gives no preamble.
- R3: After the preamble come `SYNC_BYTES` bytes taken from `cfg_sync`. Byte k is `cfg_sync[8k+7:8k]`, and the highest-numbered byte is sent first.
- R4: Next come min(`cfg_hdr_count`, `HDR_MAX`) header bytes. Byte k is `cfg_hdr[8k+7:8k]`, and they are sent from the highest-numbered byte down to byte 0.
- R5: The payload is exactly `cfg_pay_len` bytes. A byte is taken on a rising edge where both `pay_valid` and `pay_ready` are high. While `pay_valid` is low, the block waits and emits no chip. `pay_ready` is never high outside a packet.
- R6: Sync, header and payload bytes go out MSB first when `cfg_lsb_first` is 0. When it is 1, each of these bytes goes out bit 0 first. The checksum is always sent MSB first.
- R7: When `cfg_whiten_en` is 1, each payload data bit is XORed with the output s[0] of a 9-bit register. The register is loaded with all ones at the start of the payload and steps to {s[0]^s[5], s[8:1]} after every payload bit. No other field is whitened.
- R8: When `cfg_manch_en` is 1, every data bit after the preamble becomes two chips: 1 gives chips 1 then 0, and 0 gives chips 0 then 1.
- R9: The checksum is a 16-bit CRC with polynomial 0x1021 and initial value 0xFFFF, with no final inversion. It is computed MSB first over the unwhitened header and payload bytes and sent as 16 bits, MSB first.
- R10: `busy` rises on the cycle after an accepted `start` and falls after the last checksum chip. `sent` is cleared by an accepted `start`, set when `busy` falls, and is never high together with `busy`.
- R11: A `start` pulse while `busy` is high is ignored, and the packet in flight is unchanged.
- R12: The packet's chips appear, in order, exactly on the cycles where `bit_en` is high. `bit_en` is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pre_nibbles | input | PRE_W | Preamble length in 4-chip units |
| cfg_sync | input | 8×SYNC_BYTES | Sync word bytes |
| cfg_hdr_count | input | clog2(HDR_MAX+1) | Number of header bytes |
| cfg_hdr | input | 8×HDR_MAX | Header bytes |
| cfg_pay_len | input | LEN_W | Payload length in bytes |
| cfg_whiten_en | input | 1 | Whiten the payload |
| cfg_manch_en | input | 1 | Manchester-code everything after the preamble |
| cfg_lsb_first | input | 1 | Send data bytes bit 0 first |
| start | input | 1 | Launch one packet |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Payload byte taken on this edge if valid |
| bit_out | output | 1 | Serial chip |
| bit_en | output | 1 | `bit_out` carries a chip this cycle |
| busy | output | 1 | Packet in progress |
| sent | output | 1 | Last packet completed |

## Verification
The checker watches status and handshake rules on every cycle. It checks that `sent` and `busy` are never high together, that `sent` only rises as a packet ends, and that the payload handshake and chip strobe stay quiet outside a packet. It also checks that preamble chips alternate and that a second `start` never sends the engine back to its preamble. Field ordering, bit reversal, whitening, Manchester pairs and checksum values can only be shown by the bench. The bench sweeps preamble, header and payload lengths, including the clamped header count and empty fields, across all eight option combinations. It compares the whole chip stream against a model built from the requirements.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_SYNC,
      ST_HDR,
      ST_PAY,
      ST_CRC
   } tpa_state_e;

   function automatic logic [7:0] tpa_rev8(input logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

endpackage

// File: rtl/tpa_crc16.sv
module tpa_crc16 #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        upd,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   logic [15:0] nxt;

   always_comb begin
      nxt = crc;
      for (int i = 7; i >= 0; i--) begin
         if (nxt[15] ^ din[i]) nxt = {nxt[14:0], 1'b0} ^ POLY;
         else                  nxt = {nxt[14:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= SEED;
      else if (init) crc <= SEED;
      else if (upd)  crc <= nxt;
   end
endmodule

// File: rtl/tpa_pn9.sv
module tpa_pn9 (
   input  logic clk,
   input  logic rst_n,
   input  logic seed,
   input  logic step,
   output logic pn_bit
);
   logic [8:0] s;

   assign pn_bit = s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    s <= '1;
      else if (seed) s <= '1;
      else if (step) s <= {s[0] ^ s[5], s[8:1]};
   end
endmodule

// File: rtl/tpa_chip_coder.sv
module tpa_chip_coder #(
   parameter bit MANCH_SUPPORT = 1'b1
) (
   input  logic data_bit,
   input  logic whiten,
   input  logic pn_bit,
   input  logic manch_on,
   input  logic second_half,
   output logic chip,
   output logic bit_done
);
   logic b;
   assign b = data_bit ^ (whiten & pn_bit);

   generate
      if (MANCH_SUPPORT) begin : g_manch
         assign chip     = (manch_on & second_half) ? ~b : b;
         assign bit_done = ~manch_on | second_half;
      end else begin : g_plain
         assign chip     = b;
         assign bit_done = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tx_pkt_assembler.sv
module tx_pkt_assembler #(
   parameter int SYNC_BYTES    = 2,
   parameter int HDR_MAX       = 4,
   parameter int LEN_W         = 8,
   parameter int PRE_W         = 9,
   parameter bit MANCH_SUPPORT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [PRE_W-1:0]             cfg_pre_nibbles,
   input  logic [8*SYNC_BYTES-1:0]      cfg_sync,
   input  logic [$clog2(HDR_MAX+1)-1:0] cfg_hdr_count,
   input  logic [8*HDR_MAX-1:0]         cfg_hdr,
   input  logic [LEN_W-1:0]             cfg_pay_len,
   input  logic                         cfg_whiten_en,
   input  logic                         cfg_manch_en,
   input  logic                         cfg_lsb_first,
   input  logic                         start,
   input  logic [7:0]                   pay_data,
   input  logic                         pay_valid,
   output logic                         pay_ready,
   output logic                         bit_out,
   output logic                         bit_en,
   output logic                         busy,
   output logic                         sent
);
   import tpa_pkg::*;

   localparam int HC_W   = $clog2(HDR_MAX + 1);
   localparam int PCNT_W = PRE_W + 2;
   localparam int CNT_W  = 5;

   generate
      if (SYNC_BYTES < 1 || SYNC_BYTES > 8) begin : g_bad_sync
         $error("SYNC_BYTES must lie in 1..8");
      end
      if (HDR_MAX < 1 || HDR_MAX >= (1 << LEN_W)) begin : g_bad_hdr
         $error("HDR_MAX must be at least 1 and fit in LEN_W bits");
      end
   endgenerate

   tpa_state_e        st;
   logic [PCNT_W-1:0] pre_left;
   logic [LEN_W-1:0]  left;
   logic [CNT_W-1:0]  cnt;
   logic              half;
   logic [15:0]       sh;
   logic              sent_q;

   logic [LEN_W-1:0]  left_m1, hdr_eff;
   logic [7:0]        sync_byte, hdr_byte;
   logic              in_bytes, loading, pn_bit, chip, bit_done;
   logic              crc_upd, pn_seed, pn_step;
   logic [15:0]       crc;

   assign left_m1   = left - LEN_W'(1);
   assign hdr_eff   = (cfg_hdr_count > HC_W'(HDR_MAX)) ? LEN_W'(HDR_MAX) : LEN_W'(cfg_hdr_count);
   assign sync_byte = 8'(cfg_sync >> {left_m1, 3'b000});
   assign hdr_byte  = 8'(cfg_hdr  >> {left_m1, 3'b000});

   assign in_bytes  = (st == ST_SYNC) || (st == ST_HDR) || (st == ST_PAY) || (st == ST_CRC);
   assign loading   = in_bytes && (cnt == '0);
   assign busy      = (st != ST_IDLE);
   assign sent      = sent_q;
   assign pay_ready = (st == ST_PAY) && loading && (left != '0);
   assign bit_en    = ((st == ST_PRE) && (pre_left != '0)) || (in_bytes && (cnt != '0));
   assign bit_out   = (st == ST_PRE) ? ~pre_left[0] : chip;

   assign crc_upd = ((st == ST_HDR) && loading && (left != '0)) || (pay_ready && pay_valid);
   assign pn_seed = (st == ST_HDR) && loading && (left == '0);
   assign pn_step = (st == ST_PAY) && (cnt != '0) && bit_done;

   tpa_crc16 u_crc (
      .clk(clk), .rst_n(rst_n),
      .init((st == ST_IDLE) && start),
      .upd(crc_upd),
      .din((st == ST_HDR) ? hdr_byte : pay_data),
      .crc(crc)
   );

   tpa_pn9 u_pn (
      .clk(clk), .rst_n(rst_n), .seed(pn_seed), .step(pn_step), .pn_bit(pn_bit)
   );

   tpa_chip_coder #(.MANCH_SUPPORT(MANCH_SUPPORT)) u_coder (
      .data_bit(sh[15]),
      .whiten((st == ST_PAY) && cfg_whiten_en),
      .pn_bit(pn_bit),
      .manch_on(cfg_manch_en && in_bytes),
      .second_half(half),
      .chip(chip),
      .bit_done(bit_done)
   );

   function automatic logic [15:0] place(input logic [7:0] b, input logic lsb);
      return {lsb ? tpa_rev8(b) : b, 8'h00};
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         pre_left <= '0;
         left     <= '0;
         cnt      <= '0;
         half     <= 1'b0;
         sh       <= '0;
         sent_q   <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st       <= ST_PRE;
               pre_left <= {cfg_pre_nibbles, 2'b00};
               cnt      <= '0;
               half     <= 1'b0;
               sent_q   <= 1'b0;
            end
            ST_PRE: begin
               if (pre_left != '0) pre_left <= pre_left - PCNT_W'(1);
               else begin
                  st   <= ST_SYNC;
                  left <= LEN_W'(SYNC_BYTES);
               end
            end
            default: begin
               if (cnt != '0) begin
                  if (bit_done) begin
                     sh   <= {sh[14:0], 1'b0};
                     cnt  <= cnt - CNT_W'(1);
                     half <= 1'b0;
                  end else begin
                     half <= 1'b1;
                  end
               end else begin
                  case (st)
                     ST_SYNC: if (left != '0) begin
                        sh <= place(sync_byte, cfg_lsb_first); cnt <= CNT_W'(8); left <= left_m1;
                     end else begin
                        st <= ST_HDR; left <= hdr_eff;
                     end
                     ST_HDR: if (left != '0) begin
                        sh <= place(hdr_byte, cfg_lsb_first); cnt <= CNT_W'(8); left <= left_m1;
                     end else begin
                        st <= ST_PAY; left <= cfg_pay_len;
                     end
                     ST_PAY: if (left != '0) begin
                        if (pay_valid) begin
                           sh <= place(pay_data, cfg_lsb_first); cnt <= CNT_W'(8); left <= left_m1;
                        end
                     end else begin
                        st <= ST_CRC; left <= LEN_W'(1);
                     end
                     ST_CRC: if (left != '0) begin
                        sh <= crc; cnt <= CNT_W'(16); left <= '0;
                     end else begin
                        st <= ST_IDLE; sent_q <= 1'b1;
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tpa_checker.sv
module tpa_checker (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             sent,
   input logic             bit_en,
   input logic             bit_out,
   input logic             pay_ready,
   input tpa_pkg::tpa_state_e st
);
   import tpa_pkg::*;

   // R10: completion flag and activity flag exclude each other
   p_sent_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && sent));

   // R10: completion is only reported as a packet ends
   p_sent_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sent) |-> $past(busy));

   // R5: payload handshake only inside a packet and never on a chip cycle
   p_ready_in_pkt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> (busy && !bit_en));

   // R12: no chip strobe while idle
   p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bit_en);

   // R2: consecutive preamble chips alternate
   p_pre_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PRE && bit_en && $past(st == ST_PRE && bit_en)) |-> (bit_out != $past(bit_out)));

   // R11: a start beyond the preamble never restarts the engine
   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && st != ST_PRE) |=> (st != ST_PRE));
endmodule

bind tx_pkt_assembler tpa_checker u_tpa_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sent(sent),
   .bit_en(bit_en), .bit_out(bit_out), .pay_ready(pay_ready), .st(st)
);

// File: tb/test_tx_pkt_assembler.sv
module test_tx_pkt_assembler;
   localparam int SYNC_BYTES = 2;
   localparam int HDR_MAX    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  cfg_pre_nibbles = '0;
   logic [15:0] cfg_sync = 16'hD391;
   logic [2:0]  cfg_hdr_count = '0;
   logic [31:0] cfg_hdr = 32'hA1B2C3D4;
   logic [7:0]  cfg_pay_len = '0;
   logic        cfg_whiten_en = 1'b0, cfg_manch_en = 1'b0, cfg_lsb_first = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  pay_data = '0;
   logic        pay_valid = 1'b0;
   logic        pay_ready, bit_out, bit_en, busy, sent;

   int checks = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;

   tx_pkt_assembler i_tx_pkt_assembler (
      .clk(clk), .rst_n(rst_n), .cfg_pre_nibbles(cfg_pre_nibbles), .cfg_sync(cfg_sync),
      .cfg_hdr_count(cfg_hdr_count), .cfg_hdr(cfg_hdr), .cfg_pay_len(cfg_pay_len),
      .cfg_whiten_en(cfg_whiten_en), .cfg_manch_en(cfg_manch_en), .cfg_lsb_first(cfg_lsb_first),
      .start(start), .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
      .bit_out(bit_out), .bit_en(bit_en), .busy(busy), .sent(sent)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog R12: actual hung run expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   bit    exp_q[$];
   string tag_q[$];
   bit    got_q[$];

   function automatic logic [7:0] pay_byte(input int i, input int salt);
      return 8'(i * 37 + salt * 11 + 5);
   endfunction

   function automatic void put_bit(input bit b, input bit manch, input string tag);
      exp_q.push_back(b); tag_q.push_back(tag);
      if (manch) begin exp_q.push_back(!b); tag_q.push_back(tag); end
   endfunction

   task automatic build(input int salt);
      logic [15:0] crc = 16'hFFFF;
      logic [8:0]  s = 9'h1FF;
      int          nh;
      logic [7:0]  b;
      string       sfx;
      exp_q.delete(); tag_q.delete();
      sfx = {cfg_lsb_first ? " R6" : "", cfg_manch_en ? " R8" : ""};
      for (int i = 0; i < 4 * int'(cfg_pre_nibbles); i++)
         put_bit((i % 2) == 0, 1'b0, "R2 preamble");
      for (int k = SYNC_BYTES - 1; k >= 0; k--) begin
         b = cfg_sync[8*k +: 8];
         for (int j = 0; j < 8; j++)
            put_bit(cfg_lsb_first ? b[j] : b[7-j], cfg_manch_en, {"R3 sync", sfx});
      end
      nh = (int'(cfg_hdr_count) > HDR_MAX) ? HDR_MAX : int'(cfg_hdr_count);
      for (int k = nh - 1; k >= 0; k--) begin
         b = cfg_hdr[8*k +: 8];
         for (int j = 7; j >= 0; j--) crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ b[j]) ? 16'h1021 : 16'h0);
         for (int j = 0; j < 8; j++)
            put_bit(cfg_lsb_first ? b[j] : b[7-j], cfg_manch_en, {"R4 header", sfx});
      end
      for (int i = 0; i < int'(cfg_pay_len); i++) begin
         b = pay_byte(i, salt);
         for (int j = 7; j >= 0; j--) crc = {crc[14:0], 1'b0} ^ ((crc[15] ^ b[j]) ? 16'h1021 : 16'h0);
         for (int j = 0; j < 8; j++) begin
            bit d = cfg_lsb_first ? b[j] : b[7-j];
            if (cfg_whiten_en) d = d ^ s[0];
            s = {s[0] ^ s[5], s[8:1]};
            put_bit(d, cfg_manch_en, {cfg_whiten_en ? "R7 payload" : "R5 payload", sfx});
         end
      end
      for (int j = 15; j >= 0; j--)
         put_bit(crc[j], cfg_manch_en, cfg_manch_en ? "R9 crc R8" : "R9 crc");
   endtask

   task automatic run_pkt(input int salt, input bit inject);
      int idx = 0, n = 0, bad = -1;
      build(salt);
      got_q.delete();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", busy, 1);
      chk(sent == 1'b0, "R10 sent cleared by start", sent, 0);
      while (busy) begin
         if (bit_en) got_q.push_back(bit_out);
         pay_data  = pay_byte(idx, salt);
         pay_valid = ((n % 4) != 3) && (idx < int'(cfg_pay_len));
         if (pay_ready && pay_valid) idx++;
         start = inject && (n == 12);
         n++;
         @(negedge clk);
      end
      start = 1'b0; pay_valid = 1'b0;
      chk(sent == 1'b1, "R10 sent at end", sent, 1);
      chk(idx == int'(cfg_pay_len), "R5 payload bytes taken", idx, cfg_pay_len);
      chk(got_q.size() == exp_q.size(), inject ? "R11 R12 chip count" : "R12 chip count",
          got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
      if (bad >= 0)
         chk(1'b0, $sformatf("%s chip %0d pre=%0d hdr=%0d len=%0d%s", tag_q[bad], bad,
             cfg_pre_nibbles, cfg_hdr_count, cfg_pay_len, inject ? " R11" : ""),
             got_q[bad], exp_q[bad]);
      else
         chk(1'b1, "stream", 0, 0);
   endtask

   initial begin
      int pkt = 0;
      int pres[3] = '{0, 1, 3};
      int hdrs[4] = '{0, 2, 4, 5};
      int lens[3] = '{0, 1, 3};
      repeat (3) @(negedge clk);
      chk(busy == 0 && sent == 0 && bit_en == 0 && pay_ready == 0, "R1 reset outputs",
          {busy, sent, bit_en, pay_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && bit_en == 0, "R1 idle after reset", {busy, bit_en}, 0);
      for (int opt = 0; opt < 8; opt++)
         for (int p = 0; p < 3; p++)
            for (int h = 0; h < 4; h++)
               for (int l = 0; l < 3; l++) begin
                  cfg_whiten_en   = opt[0];
                  cfg_manch_en    = opt[1];
                  cfg_lsb_first   = opt[2];
                  cfg_pre_nibbles = 9'(pres[p]);
                  cfg_hdr_count   = 3'(hdrs[h]);
                  cfg_pay_len     = 8'(lens[l]);
                  cfg_hdr         = 32'hA1B2C3D4 ^ {4{8'(pkt)}};
                  run_pkt(pkt, (pkt % 5) == 2);
                  pkt++;
               end
      cfg_whiten_en = 1'b1; cfg_manch_en = 1'b0; cfg_lsb_first = 1'b0;
      cfg_pre_nibbles = 9'd8; cfg_hdr_count = 3'd3; cfg_pay_len = 8'd20;
      run_pkt(99, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule